// File: doc/BRIEF.md
# Reverse-Direction FIFO DMA Request Controller

This block generates the DMA request level for a parallel-port receive FIFO whose bytes flow toward the host. It watches the FIFO occupancy, the DMA acknowledge, the terminal-count strobe, the host read strobe and a service-disable control bit. It raises the request while bytes are waiting, withdraws it when the transfer has to pause, and decides when a new request is allowed.

Transfers can pause in two ways, and each re-arms differently. A pause caused by draining the FIFO re-arms by itself as soon as a new byte lands. A pause caused by a qualified terminal count is recorded in a sticky flag. That flag is cleared only when software takes the service-disable bit from 1 back to 0. On the last byte of a burst the request is withdrawn on the rising acknowledge. When the acknowledge stays high through the whole burst, the rising read strobe withdraws it instead. All edges are found by comparing each input with a registered copy of itself in the block's single clock domain.

Top module: `fifo_drq_ctrl`

## Requirements
- R1: During and after synchronous reset, `drq` and `tc_stop` are 0.
- R2: When a clock edge samples `fifo_empty`=0, `svc_off`=0 and no pending stop, `drq` is 1 after that edge.
- R3: When an edge samples `svc_off`=1, `drq` is 0 after that edge. `tc_stop` is unchanged by the edge while `svc_off` stays 1.
- R4: When an edge samples `fifo_empty`=1, `drq` is 0 after that edge. A drained FIFO re-arms on the first later byte without any software action.
- R5: A terminal count counts only when `tc` and `dack` are both 1 at the same edge. It then sets `tc_stop` and clears `drq` after that edge. `tc` with `dack`=0 has no effect.
- R6: When `fifo_count`==1 and `dack` rises (1 now, 0 at the previous edge), `drq` is 0 after that edge. It stays 0 until an edge has sampled `fifo_empty`=1.
- R7: When `fifo_count`==1 and `dack` was already 1 at the previous edge, a rising `rd_strobe` withdraws `drq` in the same way as in R6.
- R8: While `tc_stop` is 1, incoming bytes do not raise `drq`. A 1-to-0 transition of `svc_off` clears `tc_stop` and lets `drq` rise again when a byte is present.
- R9: If a qualified terminal count and a 1-to-0 transition of `svc_off` arrive at the same edge, `tc_stop` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_count | input | CNT_W | Number of bytes in the FIFO |
| dack | input | 1 | DMA acknowledge, active high |
| tc | input | 1 | Terminal-count strobe from the DMA controller |
| rd_strobe | input | 1 | Host read strobe, active high |
| svc_off | input | 1 | Service disable; 1 blocks requests |
| drq | output | 1 | DMA request level |
| tc_stop | output | 1 | Sticky terminal-count stop flag |

## Verification
The bench uses the default `CNT_W` of 5. It keeps random counts between 0 and 3, so the one-byte-left boundary comes up often in both last-byte paths. The service bit is randomized together with terminal counts, which brings the clear-versus-set collision of R9 and the terminal-count re-arm into reach. Directed sequences place a held acknowledge before a read-strobe edge and check that the request stays low between the last byte and the empty indication.

// File: rtl/drq_pkg.sv
package drq_pkg;

    // Edge view of the acknowledge, read strobe and service bit.
    typedef struct packed {
        logic dack_rise;
        logic dack_held;
        logic rd_rise;
        logic svc_fall;
    } edge_s;

    // Pending stop state held by the tracker.
    typedef struct packed {
        logic tc_stop;
        logic drain_lock;
    } stop_s;

    localparam int EDGE_N   = 3;
    localparam int IDX_DACK = 0;
    localparam int IDX_RD   = 1;
    localparam int IDX_SVC  = 2;

    // Last-byte withdraw: the acknowledge edge, or the read edge while the
    // acknowledge was already held high.
    function automatic logic last_take(input edge_s e, input logic one_left);
        return one_left & (e.dack_rise | (e.rd_rise & e.dack_held));
    endfunction

endpackage

// File: rtl/drq_edge_det.sv
module drq_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] prev,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/drq_stop_track.sv
module drq_stop_track
    import drq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tc_hit,
    input  logic  svc_fall,
    input  logic  svc_off,
    input  logic  last_hit,
    input  logic  fifo_empty,
    output stop_s nxt,
    output stop_s cur
);
    always_comb begin
        nxt = cur;
        if (tc_hit)        nxt.tc_stop = 1'b1;
        else if (svc_fall) nxt.tc_stop = 1'b0;
        if (last_hit)        nxt.drain_lock = 1'b1;
        else if (fifo_empty) nxt.drain_lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assert_tc_sets_R5: assert property (@(posedge clk) disable iff (rst)
        tc_hit |=> cur.tc_stop);
    assert_tc_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (tc_hit && svc_fall) |=> cur.tc_stop);
    assert_tc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cur.tc_stop && svc_off) |=> cur.tc_stop);
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cur.drain_lock && !fifo_empty) |=> cur.drain_lock);
endmodule

// File: rtl/drq_req_reg.sv
module drq_req_reg
    import drq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  svc_off,
    input  logic  fifo_empty,
    input  stop_s stop_nxt,
    output logic  drq
);
    logic want;

    always_comb begin
        want = ~svc_off & ~fifo_empty & ~stop_nxt.tc_stop & ~stop_nxt.drain_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) drq <= 1'b0;
        else     drq <= want;
    end

    assert_svc_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        svc_off |=> !drq);
    assert_empty_drops_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> !drq);
endmodule

// File: rtl/fifo_drq_ctrl.sv
module fifo_drq_ctrl
    import drq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_empty,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             dack,
    input  logic             tc,
    input  logic             rd_strobe,
    input  logic             svc_off,
    output logic             drq,
    output logic             tc_stop
);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    logic [EDGE_N-1:0] raw, prev, rise, fall;
    edge_s             ev;
    stop_s             stop_nxt, stop_cur;
    logic              tc_hit, last_hit;

    assign raw[IDX_DACK] = dack;
    assign raw[IDX_RD]   = rd_strobe;
    assign raw[IDX_SVC]  = svc_off;

    drq_edge_det #(.N(EDGE_N)) edge_i (
        .clk (clk),
        .rst (rst),
        .sig (raw),
        .prev(prev),
        .rise(rise),
        .fall(fall)
    );

    always_comb begin
        ev.dack_rise = rise[IDX_DACK];
        ev.dack_held = prev[IDX_DACK];
        ev.rd_rise   = rise[IDX_RD];
        ev.svc_fall  = fall[IDX_SVC];
    end

    assign tc_hit   = tc & dack;
    assign last_hit = last_take(ev, fifo_count == ONE_LEFT);

    drq_stop_track track_i (
        .clk       (clk),
        .rst       (rst),
        .tc_hit    (tc_hit),
        .svc_fall  (ev.svc_fall),
        .svc_off   (svc_off),
        .last_hit  (last_hit),
        .fifo_empty(fifo_empty),
        .nxt       (stop_nxt),
        .cur       (stop_cur)
    );

    drq_req_reg req_i (
        .clk       (clk),
        .rst       (rst),
        .svc_off   (svc_off),
        .fifo_empty(fifo_empty),
        .stop_nxt  (stop_nxt),
        .drq       (drq)
    );

    assign tc_stop = stop_cur.tc_stop;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!drq && !tc_stop));
    assert_tc_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        drq |-> !tc_stop);
    assert_last_dack_R6: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == ONE_LEFT && dack && !prev[IDX_DACK]) |=> !drq);
    assert_last_rd_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == ONE_LEFT && prev[IDX_DACK] && rd_strobe && !prev[IDX_RD]) |=> !drq);
    assert_tc_needs_dack_R5: assert property (@(posedge clk) disable iff (rst)
        (!tc_stop && !(tc && dack)) |=> !tc_stop);
endmodule

// File: tb/fifo_drq_ctrl_tb_top.sv
module fifo_drq_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fifo_empty = 1'b1;
    logic [CNT_W-1:0] fifo_count = '0;
    logic             dack = 1'b0, tc = 1'b0, rd_strobe = 1'b0, svc_off = 1'b0;
    logic             drq, tc_stop;

    int total = 0;
    int bad   = 0;

    // Reference state, derived from the requirements.
    logic m_dq = 0, m_rq = 0, m_sq = 0, m_tc = 0, m_lock = 0;

    always #(CLK_P/2) clk = ~clk;

    fifo_drq_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
        .dack(dack), .tc(tc), .rd_strobe(rd_strobe), .svc_off(svc_off),
        .drq(drq), .tc_stop(tc_stop)
    );

    function automatic logic exp_last(input int c, input logic d, input logic r,
                                      input logic dq, input logic rq);
        return (c == 1) && ((d && !dq) || (r && !rq && dq));
    endfunction

    task automatic check(input string tag, input logic ed, input logic et);
        total++;
        if (drq !== ed || tc_stop !== et) begin
            bad++;
            $display("FAIL %s drq=%0b tc_stop=%0b expected drq=%0b tc_stop=%0b",
                     tag, drq, tc_stop, ed, et);
        end
    endtask

    task automatic step(input int c, input logic d, input logic t, input logic r,
                        input logic s, input string tag);
        logic sf, lst, ntc, nlk, ed;
        @(negedge clk);
        fifo_count = CNT_W'(c);
        fifo_empty = (c == 0);
        dack = d; tc = t; rd_strobe = r; svc_off = s;
        sf  = m_sq && !s;
        lst = exp_last(c, d, r, m_dq, m_rq);
        ntc = (t && d) ? 1'b1 : (sf ? 1'b0 : m_tc);
        nlk = lst ? 1'b1 : ((c == 0) ? 1'b0 : m_lock);
        ed  = !s && (c != 0) && !ntc && !nlk;
        m_dq = d; m_rq = r; m_sq = s; m_tc = ntc; m_lock = nlk;
        @(posedge clk);
        #(CLK_P/4);
        check(tag, ed, ntc);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1", 1'b0, 1'b0);
        @(negedge clk);
        fifo_count = 5'd3; fifo_empty = 1'b0;
        @(posedge clk); #(CLK_P/4);
        check("R1", 1'b0, 1'b0);           // still in reset
        @(negedge clk); rst = 1'b0;
        fifo_count = '0; fifo_empty = 1'b1;

        // R2: a byte raises the request
        step(0, 0, 0, 0, 0, "R2");
        step(2, 0, 0, 0, 0, "R2");
        step(3, 0, 0, 0, 0, "R2");
        // R3: service disable blocks the request
        step(3, 0, 0, 0, 1, "R3");
        step(3, 0, 0, 0, 0, "R3");
        // R4: empty drops, next byte re-arms
        step(0, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R4");
        // R5: tc without dack ignored, with dack stops
        step(2, 0, 1, 0, 0, "R5");
        step(2, 1, 1, 0, 0, "R5");
        step(2, 0, 0, 0, 0, "R5");
        // R8: bytes alone do not re-arm, service toggle does
        step(4, 0, 0, 0, 0, "R8");
        step(4, 0, 0, 0, 1, "R8");
        step(4, 0, 0, 0, 0, "R8");
        step(4, 0, 0, 0, 0, "R8");
        // R6: last byte on rising acknowledge, low until empty seen
        step(1, 1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");
        // R7: acknowledge held high, read strobe edge on last byte
        step(2, 1, 0, 0, 0, "R7");
        step(2, 1, 0, 1, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 1, 0, "R7");
        step(1, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, "R7");
        // R9: tc and service fall together
        step(2, 0, 0, 0, 1, "R9");
        step(2, 1, 1, 0, 0, "R9");
        step(2, 0, 0, 0, 0, "R9");

        for (int i = 0; i < 4000; i++) begin
            int c;
            c = ($urandom % 4 == 0) ? 0 : int'($urandom % 4);
            step(c, ($urandom % 3) == 0, ($urandom % 8) == 0,
                 ($urandom % 2) == 0, ($urandom % 6) == 0, "R2");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule